// File: doc/BRIEF.md
# Dual Timer/Counter with Overflow Toggle

This block holds two identical count engines. Each engine counts either machine-cycle ticks, which makes it a timer, or falling edges on its own external pin, which makes it an event counter. Each engine keeps a high byte and a low byte, which can be read and written through one shared byte port. Three count shapes are available: a 13-bit prescaled counter, a full 16-bit counter, and an 8-bit counter that reloads from the high byte when it overflows.

Every overflow sets a sticky flag, which software clears with a pulse. An engine can also invert a toggle output on each overflow, and each engine enables this on its own. Counting depends on a run control and an optional gate. When gating is enabled, the engine counts only while its gate input is high. In counter use, the external pin is sampled once on each machine-cycle strobe, so a pulse that starts and ends between two strobes is not seen.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, every count byte reads 0x00, and every overflow flag and toggle output is 0.
- R2: In timer use (`cnt_sel`=0), an enabled engine adds one on every cycle that `mc_tick` is high and holds on every other cycle.
- R3: In counter use (`cnt_sel`=1), the external pin is sampled only on `mc_tick` cycles. The count rises by one when the previous sample is 1 and the current sample is 0, so a low pulse that falls between two ticks is not counted.
- R4: An engine counts only while its `run` bit is 1 and either its `gate_en` bit is 0 or its `gate_in` is 1.
- R5: Mode code 0 counts 13 bits: the high byte is the upper part and low-byte bits 4:0 are the lower part. Going past 0x1FFF wraps that field to zero and raises overflow. Low-byte bits 7:5 keep their value.
- R6: Mode code 1 counts the 16-bit value {high, low}. Going past 0xFFFF wraps to 0x0000 and raises overflow.
- R7: Mode code 2 counts the low byte only. When the low byte is 0xFF, the next increment loads it from the high byte and raises overflow. The high byte never changes from counting.
- R8: An overflow flag stays set until a `flag_clr` pulse for that engine. If an overflow and a clear happen in the same cycle, the flag ends up set.
- R9: With `tog_en` set, the engine's toggle output inverts on each overflow. With `tog_en` clear, the output keeps its value.
- R10: A byte write to an engine in the same cycle as an increment stores the written data. That engine does not count and does not overflow in that cycle.
- R11: The two engines are independent. Counting, writes and overflows of one engine leave the other engine's bytes, flag and toggle output unchanged.
- R12: `rd_data` shows, in the same cycle, the byte picked by `rd_sel` and `rd_hi` (1 = high byte).
- R13: Mode code 3 holds both bytes whatever the tick, run and gate inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe |
| ext_in | input | N_TIMERS | External count pins, one per engine |
| gate_in | input | N_TIMERS | Gate inputs |
| run | input | N_TIMERS | Run enables |
| gate_en | input | N_TIMERS | Gate enables |
| cnt_sel | input | N_TIMERS | 1 = count pin falling edges, 0 = count ticks |
| mode_sel | input | 2*N_TIMERS | Mode code per engine, two bits each |
| tog_en | input | N_TIMERS | Toggle-on-overflow enables |
| flag_clr | input | N_TIMERS | Overflow flag clear pulses |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | IDX_W | Engine index for the write |
| wr_hi | input | 1 | 1 = write the high byte, 0 = write the low byte |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | IDX_W | Engine index for the read |
| rd_hi | input | 1 | 1 = read the high byte |
| rd_data | output | CNT_W | Selected byte |
| ovf_flag | output | N_TIMERS | Sticky overflow flags |
| tog_out | output | N_TIMERS | Overflow toggle outputs |

## Verification
A wrong count byte can be seen on `rd_data` in the cycle after the bad increment, through the ordinary read mux. A wrong carry chain or reload path first shows at the wrap point: as a flag that rises one count early or late, as a toggle output that changes on the wrong edge, or as a reloaded low byte that does not equal the high byte. A stale sample in the pin edge detector shows as a count that is off by one after the first falling edge. Mistakes in write priority or in engine independence show as a byte that differs from the written or untouched value at the next read.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [1:0] {
      CM_13B    = 2'd0,
      CM_16B    = 2'd1,
      CM_RELOAD = 2'd2,
      CM_HOLD   = 2'd3
   } cnt_mode_e;
endpackage

// File: rtl/dtc_event_src.sv
// Produces one increment request per qualified event for a single engine.
module dtc_event_src #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_tick,
   input  logic ext_in,
   input  logic cnt_sel,
   input  logic run,
   input  logic gate_en,
   input  logic gate_in,
   output logic inc
);
   logic pin_s;      // pin value after optional synchronizer
   logic last_smp;   // sample taken at the previous machine-cycle tick
   logic fall_evt;
   logic enabled;

   if (SYNC_STAGES != 0 && SYNC_STAGES < 2) begin : g_bad_sync
      $error("dtc_event_src: SYNC_STAGES must be 0 or at least 2");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_s = ext_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2:0], ext_in};
      end
      assign pin_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_smp <= 1'b0;
      else if (mc_tick) last_smp <= pin_s;
   end

   assign fall_evt = mc_tick & last_smp & ~pin_s;
   assign enabled  = run & (~gate_en | gate_in);
   assign inc      = enabled & (cnt_sel ? fall_evt : mc_tick);
endmodule

// File: rtl/dtc_count_core.sv
// High/low count bytes with the three count shapes and write priority.
module dtc_count_core
   import dtc_pkg::*;
#(
   parameter int W        = 8,
   parameter int M0_LOW_W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  cnt_mode_e    mode,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] th_q,
   output logic [W-1:0] tl_q,
   output logic         ovf
);
   localparam int M0_W = W + M0_LOW_W;

   logic [M0_W:0]  sum13;
   logic [2*W:0]   sum16;
   logic [W-1:0]   tl_inc;
   logic [W-1:0]   nx_th, nx_tl;

   assign sum13  = {1'b0, th_q, tl_q[M0_LOW_W-1:0]} + {{M0_W{1'b0}}, 1'b1};
   assign sum16  = {1'b0, th_q, tl_q} + {{(2*W){1'b0}}, 1'b1};
   assign tl_inc = tl_q + {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      nx_th = th_q;
      nx_tl = tl_q;
      ovf   = 1'b0;
      if (wr_lo || wr_hi) begin
         if (wr_hi) nx_th = wr_data;
         if (wr_lo) nx_tl = wr_data;
      end else if (inc) begin
         case (mode)
            CM_13B: begin
               nx_th = sum13[M0_W-1:M0_LOW_W];
               nx_tl = {tl_q[W-1:M0_LOW_W], sum13[M0_LOW_W-1:0]};
               ovf   = sum13[M0_W];
            end
            CM_16B: begin
               nx_th = sum16[2*W-1:W];
               nx_tl = sum16[W-1:0];
               ovf   = sum16[2*W];
            end
            CM_RELOAD: begin
               if (&tl_q) begin
                  nx_tl = th_q;
                  ovf   = 1'b1;
               end else begin
                  nx_tl = tl_inc;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         th_q <= '0;
         tl_q <= '0;
      end else begin
         th_q <= nx_th;
         tl_q <= nx_tl;
      end
   end
endmodule

// File: rtl/dtc_ovf_out.sv
// Sticky overflow flag and overflow-driven toggle output for one engine.
module dtc_ovf_out (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf,
   input  logic flag_clr,
   input  logic tog_en,
   output logic flag,
   output logic tog
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         tog  <= 1'b0;
      end else begin
         if (ovf)           flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (ovf && tog_en) tog <= ~tog;
      end
   end
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
   import dtc_pkg::*;
#(
   parameter int N_TIMERS    = 2,
   parameter int CNT_W       = 8,
   parameter int M0_LOW_W    = 5,
   parameter int SYNC_STAGES = 0,
   parameter int IDX_W       = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mc_tick,
   input  logic [N_TIMERS-1:0]   ext_in,
   input  logic [N_TIMERS-1:0]   gate_in,
   input  logic [N_TIMERS-1:0]   run,
   input  logic [N_TIMERS-1:0]   gate_en,
   input  logic [N_TIMERS-1:0]   cnt_sel,
   input  logic [2*N_TIMERS-1:0] mode_sel,
   input  logic [N_TIMERS-1:0]   tog_en,
   input  logic [N_TIMERS-1:0]   flag_clr,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_sel,
   input  logic                  wr_hi,
   input  logic [CNT_W-1:0]      wr_data,
   input  logic [IDX_W-1:0]      rd_sel,
   input  logic                  rd_hi,
   output logic [CNT_W-1:0]      rd_data,
   output logic [N_TIMERS-1:0]   ovf_flag,
   output logic [N_TIMERS-1:0]   tog_out
);
   if (N_TIMERS < 1) begin : g_bad_n
      $error("dual_timer_counter: N_TIMERS must be at least 1");
   end
   if (M0_LOW_W < 1 || M0_LOW_W >= CNT_W) begin : g_bad_m0
      $error("dual_timer_counter: M0_LOW_W must lie in 1..CNT_W-1");
   end
   if ((1 << IDX_W) < N_TIMERS) begin : g_bad_idx
      $error("dual_timer_counter: IDX_W too narrow for N_TIMERS");
   end

   logic [N_TIMERS-1:0][CNT_W-1:0] th_q;
   logic [N_TIMERS-1:0][CNT_W-1:0] tl_q;
   logic [N_TIMERS-1:0]            inc;
   logic [N_TIMERS-1:0]            ovf;

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_eng
      logic wr_me;
      assign wr_me = wr_en && (int'(wr_sel) == i);

      dtc_event_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .mc_tick (mc_tick),
         .ext_in  (ext_in[i]),
         .cnt_sel (cnt_sel[i]),
         .run     (run[i]),
         .gate_en (gate_en[i]),
         .gate_in (gate_in[i]),
         .inc     (inc[i])
      );

      dtc_count_core #(.W(CNT_W), .M0_LOW_W(M0_LOW_W)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc[i]),
         .mode    (cnt_mode_e'(mode_sel[2*i +: 2])),
         .wr_lo   (wr_me && !wr_hi),
         .wr_hi   (wr_me && wr_hi),
         .wr_data (wr_data),
         .th_q    (th_q[i]),
         .tl_q    (tl_q[i]),
         .ovf     (ovf[i])
      );

      dtc_ovf_out u_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .ovf      (ovf[i]),
         .flag_clr (flag_clr[i]),
         .tog_en   (tog_en[i]),
         .flag     (ovf_flag[i]),
         .tog      (tog_out[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_sel) < N_TIMERS)
         rd_data = rd_hi ? th_q[rd_sel] : tl_q[rd_sel];
   end
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk #(
   parameter int N_TIMERS = 2,
   parameter int CNT_W    = 8,
   parameter int IDX_W    = 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           mc_tick,
   input logic                           wr_en,
   input logic [IDX_W-1:0]               wr_sel,
   input logic                           wr_hi,
   input logic [CNT_W-1:0]               wr_data,
   input logic [N_TIMERS-1:0]            run,
   input logic [2*N_TIMERS-1:0]          mode_sel,
   input logic [N_TIMERS-1:0]            tog_en,
   input logic [N_TIMERS-1:0]            flag_clr,
   input logic [N_TIMERS-1:0]            ovf_flag,
   input logic [N_TIMERS-1:0]            tog_out,
   input logic [N_TIMERS-1:0][CNT_W-1:0] th_q,
   input logic [N_TIMERS-1:0][CNT_W-1:0] tl_q
);
   for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
      // R8
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_flag[i] && !flag_clr[i] |=> ovf_flag[i]);
      // R9
      tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tog_en[i] |=> $stable(tog_out[i]));
      // R9
      tog_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(tog_out[i]) |-> ovf_flag[i]);
      // R2
      no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !mc_tick && !wr_en |=> $stable(th_q[i]) && $stable(tl_q[i]));
      // R4
      stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run[i] && !wr_en |=> $stable(th_q[i]) && $stable(tl_q[i]));
      // R13
      hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mode_sel[2*i +: 2] == 2'd3 && !wr_en |=> $stable(th_q[i]) && $stable(tl_q[i]));
      // R7
      reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mode_sel[2*i +: 2] == 2'd2 && !(wr_en && int'(wr_sel) == i) |=> $stable(th_q[i]));
      // R10
      wr_lo_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && int'(wr_sel) == i && !wr_hi |=>
            tl_q[i] == $past(wr_data) && $stable(th_q[i]));
      // R10
      wr_hi_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && int'(wr_sel) == i && wr_hi |=>
            th_q[i] == $past(wr_data) && $stable(tl_q[i]));
   end
endmodule

bind dual_timer_counter dtc_chk #(
   .N_TIMERS(N_TIMERS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/dual_timer_counter_test.sv
module dual_timer_counter_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       mc_tick;
   logic [1:0] ext_in, gate_in, run, gate_en, cnt_sel, tog_en, flag_clr;
   logic [3:0] mode_sel;
   logic       wr_en, wr_sel, wr_hi, rd_sel, rd_hi;
   logic [7:0] wr_data, rd_data;
   logic [1:0] ovf_flag, tog_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dual_timer_counter uut (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_in(ext_in),
      .gate_in(gate_in), .run(run), .gate_en(gate_en), .cnt_sel(cnt_sel),
      .mode_sel(mode_sel), .tog_en(tog_en), .flag_clr(flag_clr),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data),
      .ovf_flag(ovf_flag), .tog_out(tog_out)
   );

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_byte(string req, int idx, bit hi, int exp);
      rd_sel = idx[0];
      rd_hi  = hi;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic wr(int idx, bit hi, logic [7:0] d);
      wr_en = 1'b1; wr_sel = idx[0]; wr_hi = hi; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic set_mode(int idx, logic [1:0] m);
      mode_sel[2*idx +: 2] = m;
   endtask

   task automatic t_reset;
      chk_byte("R1 tl0", 0, 0, 0);
      chk_byte("R1 th0", 0, 1, 0);
      chk_byte("R1 tl1", 1, 0, 0);
      check("R1 flags", ovf_flag, 0);
      check("R1 toggles", tog_out, 0);
   endtask

   task automatic t_timer;
      set_mode(0, 2'd1); run[0] = 1'b1;
      for (int k = 0; k < 8; k++) begin
         mc_tick = (k % 2 == 0);
         step();
      end
      mc_tick = 1'b0; run[0] = 1'b0;
      chk_byte("R2 tl0 after 4 ticks", 0, 0, 4);
      chk_byte("R2 th0", 0, 1, 0);
      chk_byte("R11 tl1 untouched", 1, 0, 0);
   endtask

   task automatic t_gate;
      gate_en[0] = 1'b1; gate_in[0] = 1'b0; run[0] = 1'b1; mc_tick = 1'b1;
      step(4);
      chk_byte("R4 gate low holds", 0, 0, 4);
      gate_in[0] = 1'b1;
      step(3);
      chk_byte("R4 gate high counts", 0, 0, 7);
      run[0] = 1'b0;
      step(2);
      chk_byte("R4 run off holds", 0, 0, 7);
      gate_en[0] = 1'b0; gate_in[0] = 1'b0;
   endtask

   task automatic t_counter;
      set_mode(1, 2'd1); cnt_sel[1] = 1'b1; run[1] = 1'b1; mc_tick = 1'b1;
      for (int k = 0; k < 3; k++) begin
         ext_in[1] = 1'b1; step(2);
         ext_in[1] = 1'b0; step(2);
      end
      chk_byte("R3 three falls", 1, 0, 3);
      ext_in[1] = 1'b1; step();
      mc_tick = 1'b0;
      ext_in[1] = 1'b0; step();
      ext_in[1] = 1'b1; step();
      mc_tick = 1'b1; step(2);
      chk_byte("R3 pulse between ticks ignored", 1, 0, 3);
      chk_byte("R11 tl0 untouched", 0, 0, 7);
      run[1] = 1'b0;
   endtask

   task automatic t_mode0;
      wr(0, 1, 8'hFF); wr(0, 0, 8'hFE);
      set_mode(0, 2'd0); tog_en[0] = 1'b1; run[0] = 1'b1; mc_tick = 1'b1;
      step();
      chk_byte("R5 tl0 at 1F", 0, 0, 8'hFF);
      check("R5 no flag yet", ovf_flag[0], 0);
      step();
      run[0] = 1'b0;
      chk_byte("R5 th0 wrapped", 0, 1, 8'h00);
      chk_byte("R5 tl0 upper bits kept", 0, 0, 8'hE0);
      check("R5 flag set", ovf_flag[0], 1);
      check("R9 toggle rose", tog_out[0], 1);
      step(3);
      check("R8 flag sticky", ovf_flag[0], 1);
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
      check("R8 flag cleared", ovf_flag[0], 0);
   endtask

   task automatic t_mode1;
      wr(0, 1, 8'hFF); wr(0, 0, 8'hFE);
      set_mode(0, 2'd1); run[0] = 1'b1;
      step();
      chk_byte("R6 tl0 FF", 0, 0, 8'hFF);
      check("R6 no flag at FFFF", ovf_flag[0], 0);
      flag_clr[0] = 1'b1;
      step();
      flag_clr[0] = 1'b0; run[0] = 1'b0;
      chk_byte("R6 tl0 wrapped", 0, 0, 0);
      chk_byte("R6 th0 wrapped", 0, 1, 0);
      check("R8 set beats clear", ovf_flag[0], 1);
      check("R9 toggle fell", tog_out[0], 0);
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
   endtask

   task automatic t_mode2;
      tog_en[0] = 1'b0;
      wr(0, 1, 8'hFC); wr(0, 0, 8'hFE);
      set_mode(0, 2'd2); run[0] = 1'b1;
      step();
      chk_byte("R7 tl0 FF", 0, 0, 8'hFF);
      step();
      chk_byte("R7 reloaded", 0, 0, 8'hFC);
      check("R7 flag", ovf_flag[0], 1);
      check("R9 toggle disabled holds", tog_out[0], 0);
      step();
      run[0] = 1'b0;
      chk_byte("R7 counts after reload", 0, 0, 8'hFD);
      chk_byte("R7 th0 unchanged", 0, 1, 8'hFC);
      flag_clr[0] = 1'b1; step(); flag_clr[0] = 1'b0;
   endtask

   task automatic t_write_prio;
      set_mode(0, 2'd1);
      wr(0, 1, 8'h00); wr(0, 0, 8'h10);
      run[0] = 1'b1;
      step();
      chk_byte("R10 pre count", 0, 0, 8'h11);
      wr(0, 0, 8'h80);
      chk_byte("R10 write wins", 0, 0, 8'h80);
      chk_byte("R10 th0 unchanged", 0, 1, 8'h00);
      step();
      chk_byte("R10 counting resumes", 0, 0, 8'h81);
      run[0] = 1'b0;
      wr(0, 1, 8'hFF); wr(0, 0, 8'hFF);
      run[0] = 1'b1;
      wr(0, 1, 8'h22);
      chk_byte("R10 th0 written", 0, 1, 8'h22);
      chk_byte("R10 tl0 not counted", 0, 0, 8'hFF);
      check("R10 no overflow", ovf_flag[0], 0);
      step();
      run[0] = 1'b0;
      chk_byte("R10 th0 carry", 0, 1, 8'h23);
      chk_byte("R10 tl0 wrap", 0, 0, 8'h00);
   endtask

   task automatic t_hold;
      set_mode(0, 2'd3); run[0] = 1'b1; mc_tick = 1'b1;
      step(5);
      run[0] = 1'b0;
      chk_byte("R13 tl0 held", 0, 0, 8'h00);
      chk_byte("R13 th0 held", 0, 1, 8'h23);
      check("R13 no flag", ovf_flag[0], 0);
   endtask

   task automatic t_read;
      chk_byte("R12 read tl1", 1, 0, 3);
      chk_byte("R12 read th1", 1, 1, 0);
      check("R11 flag1 untouched", ovf_flag[1], 0);
      check("R11 toggle1 untouched", tog_out[1], 0);
   endtask

   initial begin
      rst_n = 1'b0; mc_tick = 1'b0; ext_in = '0; gate_in = '0; run = '0;
      gate_en = '0; cnt_sel = '0; mode_sel = '0; tog_en = '0; flag_clr = '0;
      wr_en = 1'b0; wr_sel = 1'b0; wr_hi = 1'b0; wr_data = '0;
      rd_sel = 1'b0; rd_hi = 1'b0;
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_timer();
      t_gate();
      t_counter();
      t_mode0();
      t_mode1();
      t_mode2();
      t_write_prio();
      t_hold();
      t_read();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule